// File: doc/BRIEF.md
# Static Memory with Nonvolatile Shadow Copy

This block models a byte-wide static memory that has a second array of the same size beside it, acting as a nonvolatile backup. Three active-low strobes drive all external access: a chip select, an output enable and a write enable. All three are sampled on the system clock. The address and the data path are parameters, and the product build uses a 15-bit address (32,768 bytes) with 8-bit data. Input data and output data use separate ports, and a valid flag qualifies the output.

A one-cycle store request snapshots the working array into the shadow array. The store runs in two phases. First every shadow location is erased to all ones, then the working data is programmed into it, one location per clock in each phase. A recall request copies the shadow contents back into the working array, one location per clock. While either transfer runs, the block holds `busy` high and ignores every external read, write and further request. Normal access resumes on the cycle after the last transfer step.

Top module: `nvsram_shadow`

## Requirements
- R1: A write happens on a clock edge where `ce_n` and `we_n` are both low and `busy` is low, whatever the level of `oe_n`. It stores `din` at `addr`, and a later read of that address returns it.
- R2: While `ce_n` and `oe_n` are low, `we_n` is high and `busy` is low, `dout_valid` is 1 and `dout` shows the working byte at `addr`. `dout` follows any change of `addr` within the same cycle, with no strobe transition needed.
- R3: While `we_n` is low, `dout_valid` is 0 and `dout` is 0, even when `ce_n` and `oe_n` are both low.
- R4: While `ce_n` is high or `oe_n` is high, `dout_valid` is 0 and `dout` is 0.
- R5: A `store_req` sampled high while `busy` is low raises `busy` at that edge. `busy` then stays high for exactly 2×2^ADDR_W cycles: an erase pass and then a program pass, each one location per clock.
- R6: When a store ends, the shadow array holds the working contents as they stood after the edge that accepted the request. A write accepted on that same edge is included.
- R7: A `recall_req` sampled high while `busy` is low holds `busy` high for exactly 2^ADDR_W cycles. When it ends, the working array equals the shadow array.
- R8: While `busy` is high, writes leave the working array unchanged, and `dout_valid` and `dout` are 0.
- R9: `store_req` and `recall_req` sampled while `busy` is high are ignored. They neither extend nor restart the running transfer.
- R10: When `store_req` and `recall_req` are high together while idle, the store is performed and the recall is dropped.
- R11: After reset `busy` and `dout_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_valid | output | 1 | High when a read is enabled and no transfer runs |
| store_req | input | 1 | Request copy of working array into shadow |
| recall_req | input | 1 | Request copy of shadow into working array |
| busy | output | 1 | High while a store or recall runs |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8. This makes a store last 32 cycles and a recall 16, so several complete transfers fit in a short run. With this depth the bench can write every location, so each byte read after a recall has a known expected value. The wrap of the transfer index at its last value, and the change from the erase pass to the program pass, each happen many times. This gives the window-length and phase-order checks a full workout.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    XF_IDLE    = 2'd0,
    XF_ERASE   = 2'd1,
    XF_PROGRAM = 2'd2,
    XF_RECALL  = 2'd3
  } xfer_state_e;

  // Number of bytes held by an array with the given address width.
  function automatic int unsigned depth_of(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

  // Busy cycles taken by one transfer: a store walks the array twice.
  function automatic int unsigned xfer_len(input int unsigned aw, input bit is_store);
    return is_store ? 2 * depth_of(aw) : depth_of(aw);
  endfunction

endpackage

// File: rtl/nvs_access_decode.sv
module nvs_access_decode (
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy,
  output logic rd_ok,
  output logic wr_ok
);

  logic sel;

  assign sel   = !ce_n && !busy;
  // Reads need the write strobe idle; output is off during any write.
  assign rd_ok = sel && !oe_n && we_n;
  // Writes ignore the output enable.
  assign wr_ok = sel && !we_n;

endmodule

// File: rtl/nvs_xfer_engine.sv
module nvs_xfer_engine #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_req,
  input  logic              recall_req,
  output logic              busy,
  output logic [ADDR_W-1:0] idx,
  output logic              sh_we,
  output logic              sh_erase,
  output logic              wk_we,
  output logic              store_done,
  output logic              recall_done
);
  import nvs_pkg::*;

  localparam int unsigned DEPTH    = depth_of(ADDR_W);
  localparam int unsigned CNT_W    = ADDR_W + 2;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  STORE_LAST  = CNT_W'(xfer_len(ADDR_W, 1'b1) - 1);
  localparam logic [CNT_W-1:0]  RECALL_LAST = CNT_W'(xfer_len(ADDR_W, 1'b0) - 1);

  xfer_state_e state;
  logic        last;

  assign last        = (idx == LAST_IDX);
  assign busy        = (state != XF_IDLE);
  assign sh_we       = (state == XF_ERASE) || (state == XF_PROGRAM);
  assign sh_erase    = (state == XF_ERASE);
  assign wk_we       = (state == XF_RECALL);
  assign store_done  = (state == XF_PROGRAM) && last;
  assign recall_done = (state == XF_RECALL) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XF_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        XF_IDLE: begin
          idx <= '0;
          if (store_req)       state <= XF_ERASE;
          else if (recall_req) state <= XF_RECALL;
        end
        XF_ERASE: begin
          idx <= idx + 1'b1;
          if (last) state <= XF_PROGRAM;
        end
        XF_PROGRAM: begin
          idx <= idx + 1'b1;
          if (last) state <= XF_IDLE;
        end
        default: begin
          idx <= idx + 1'b1;
          if (last) state <= XF_IDLE;
        end
      endcase
    end
  end

  // Busy run length counter, used by the window checks below.
  logic [CNT_W-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R5
  erase_then_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_ERASE && last) |=> (state == XF_PROGRAM));

  // R5
  store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |-> (run_cnt == STORE_LAST));

  // R7
  recall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done |-> (run_cnt == RECALL_LAST));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !store_done && !recall_done) |=> busy);

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_we,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  input  logic [ADDR_W-1:0] xfer_idx,
  input  logic              sh_we,
  input  logic              sh_erase,
  input  logic              rcl_we,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = nvs_pkg::depth_of(ADDR_W);

  logic [DATA_W-1:0] wk_mem [DEPTH];
  logic [DATA_W-1:0] sh_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ext_we)      wk_mem[ext_addr] <= ext_wdata;
    else if (rcl_we) wk_mem[xfer_idx] <= sh_mem[xfer_idx];
  end

  always_ff @(posedge clk) begin
    if (sh_we) sh_mem[xfer_idx] <= sh_erase ? {DATA_W{1'b1}} : wk_mem[xfer_idx];
  end

  assign rd_data = wk_mem[ext_addr];

  // R8
  ext_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> !(rcl_we || sh_we));

endmodule

// File: rtl/nvsram_shadow.sv
module nvsram_shadow #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  input  logic              store_req,
  input  logic              recall_req,
  output logic              busy
);

  logic              rd_ok;
  logic              wr_ok;
  logic [ADDR_W-1:0] xfer_idx;
  logic              sh_we;
  logic              sh_erase;
  logic              wk_we;
  logic              store_done;
  logic              recall_done;
  logic [DATA_W-1:0] rd_data;

  nvs_access_decode u_decode (
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .busy  (busy),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok)
  );

  nvs_xfer_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_req   (store_req),
    .recall_req  (recall_req),
    .busy        (busy),
    .idx         (xfer_idx),
    .sh_we       (sh_we),
    .sh_erase    (sh_erase),
    .wk_we       (wk_we),
    .store_done  (store_done),
    .recall_done (recall_done)
  );

  nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arrays (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_we    (wr_ok),
    .ext_addr  (addr),
    .ext_wdata (din),
    .xfer_idx  (xfer_idx),
    .sh_we     (sh_we),
    .sh_erase  (sh_erase),
    .rcl_we    (wk_we),
    .rd_data   (rd_data)
  );

  assign dout_valid = rd_ok;
  assign dout       = rd_ok ? rd_data : '0;

  // R5
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(store_req || recall_req));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done || recall_done) |=> !busy);

  // R3
  no_out_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_valid);

endmodule

// File: tb/nvsram_shadow_bench.sv
module nvsram_shadow_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic store_req = 1'b0, recall_req = 1'b0;
  logic [DW-1:0] dout;
  logic dout_valid, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvsram_shadow #(.ADDR_W(AW), .DATA_W(DW)) u_nvsram_shadow (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid),
    .store_req(store_req), .recall_req(recall_req), .busy(busy)
  );

  // Reference model: -1 marks a byte never written.
  int wk[D];
  int sh[D];
  int mode = 0;   // 0 idle, 1 store, 2 recall
  int step = 0;

  initial begin
    for (int i = 0; i < D; i++) begin wk[i] = -1; sh[i] = -1; end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; step = 0;
    end else if (mode == 1) begin
      if (step < D) sh[step] = 255;
      else          sh[step - D] = wk[step - D];
      step++;
      if (step == 2 * D) mode = 0;
    end else if (mode == 2) begin
      wk[step] = sh[step];
      step++;
      if (step == D) mode = 0;
    end else begin
      if (!ce_n && !we_n) wk[addr] = int'(din);
      if (store_req)       begin mode = 1; step = 0; end
      else if (recall_req) begin mode = 2; step = 0; end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison, 5 ns before the next rising edge.
  always begin
    @(posedge clk);
    #15;
    if (rst_n) begin
      automatic bit eb = (mode != 0);
      automatic bit ev = !ce_n && !oe_n && we_n && !eb;
      chk("R5/R7 busy", int'(busy), int'(eb));
      chk("R2/R4 dout_valid", int'(dout_valid), int'(ev));
      if (!ev) chk("R4 dout idle", int'(dout), 0);
      else if (wk[addr] >= 0) chk("R2 dout", int'(dout), wk[addr]);
    end
  end

  task automatic drive(input logic c, input logic o, input logic w,
                       input int a, input int d, input logic s, input logic r);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = AW'(a); din = DW'(d);
    store_req = s; recall_req = r;
  endtask

  task automatic idle();
    drive(1, 1, 1, 0, 0, 0, 0);
  endtask

  function automatic int pat_a(input int i); return (i * 37 + 5) & 255; endfunction
  function automatic int pat_b(input int i); return (i * 11 + 200) & 255; endfunction

  // Counts busy cycles starting at the edge after the current drive.
  task automatic measure_busy(input string tag, input int exp);
    int n = 0;
    @(posedge clk); #1;
    while (busy && n < 4 * D) begin
      n++;
      @(posedge clk); #1;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 valid after reset", int'(dout_valid), 0);
    rst_n = 1'b1;

    // R1: fill with pattern A, output enable high
    for (int i = 0; i < D; i++) drive(0, 1, 0, i, pat_a(i), 0, 0);
    // R2: read back, address changes with strobes held
    for (int i = 0; i < D; i++) begin
      drive(0, 0, 1, i, 0, 0, 0);
      #5;
      chk("R1 R2 readback", int'(dout), pat_a(i));
    end
    // R3: write with output enable low
    drive(0, 0, 0, 5, 8'h5A, 0, 0);
    #5; chk("R3 valid during write", int'(dout_valid), 0);
    drive(0, 0, 1, 5, 0, 0, 0);
    #5; chk("R1 write with oe low", int'(dout), 8'h5A);
    // R4: chip deselected, and output disabled
    drive(1, 0, 1, 5, 0, 0, 0);
    #5; chk("R4 ce high valid", int'(dout_valid), 0);
    drive(0, 1, 1, 5, 0, 0, 0);
    #5; chk("R4 oe high dout", int'(dout), 0);

    // R5/R6: store with a write on the accepting edge
    drive(0, 1, 0, 7, 8'hC3, 1, 0);
    idle();
    #5; chk("R5 busy after store", int'(busy), 1);
    // R8: write during busy ignored; R9: requests ignored
    drive(0, 1, 0, 3, 8'h11, 1, 1);
    drive(0, 0, 1, 3, 0, 0, 0);
    #5; chk("R8 valid while busy", int'(dout_valid), 0);
    idle();
    measure_busy("R5 R9 store length", 2 * D - 4);
    drive(0, 0, 1, 3, 0, 0, 0);
    #5; chk("R8 blocked write", int'(dout), pat_a(3));

    // R7/R6: overwrite with pattern B, then recall
    for (int i = 0; i < D; i++) drive(0, 1, 0, i, pat_b(i), 0, 0);
    drive(0, 0, 1, 2, 0, 0, 0);
    #5; chk("R1 pattern B", int'(dout), pat_b(2));
    drive(1, 1, 1, 0, 0, 0, 1);
    measure_busy("R7 recall length", D);
    for (int i = 0; i < D; i++) begin
      automatic int e = (i == 5) ? 8'h5A : (i == 7) ? 8'hC3 : pat_a(i);
      drive(0, 0, 1, i, 0, 0, 0);
      #5;
      chk("R6 R7 recalled", int'(dout), e);
    end

    // R10: both requests at once, store wins
    drive(1, 1, 1, 0, 0, 1, 1);
    measure_busy("R10 store wins length", 2 * D);
    drive(0, 0, 1, 9, 0, 0, 0);
    #5; chk("R10 no recall", int'(dout), pat_a(9));

    idle(); idle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule